// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Pair

This block carries out 32-bit integer multiplication and division alongside a processor pipeline. The core starts an operation by presenting two operands and an operation code for one cycle. The unit then works on its own for a fixed number of cycles while the core carries on with unrelated instructions. When the operation finishes, the unit writes a result pair into two dedicated registers. The high register takes the upper product half or the remainder. The low register takes the lower product half or the quotient.

The core reads the pair through a single read port with a half select. While an operation is running, a read request raises a stall output, so the core waits only when it actually needs a result. Multiplication shifts and adds one bit per cycle. Division runs one restoring step per cycle. Both work on operand magnitudes, and one extra cycle applies the signs.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: Operation code 2'b00 is a signed multiply: HI receives bits 63..32 and LO bits 31..0 of the two's-complement 64-bit product of the operands.
- R2: Operation code 2'b01 is an unsigned multiply, with the same HI/LO split of the 64-bit unsigned product.
- R3: Operation code 2'b10 is a signed divide: LO receives the quotient rounded toward zero and HI the remainder, which carries the dividend's sign. The most negative value divided by -1 leaves LO = 32'h8000_0000 and HI = 0.
- R4: Operation code 2'b11 is an unsigned divide: LO receives the quotient and HI the remainder.
- R5: A divide (signed or unsigned) by zero completes normally, with LO = 32'hFFFF_FFFF and HI equal to the dividend.
- R6: A start seen while idle raises busy_o after that clock edge. busy_o stays high for exactly 33 cycles, and the new HI/LO values become readable in the cycle busy_o falls.
- R7: HI and LO keep their previous values for as long as busy_o is high.
- R8: A start presented while busy_o is high is ignored: the running operation keeps its timing and its result.
- R9: rd_data_o shows HI when rd_sel_hi_i is 1 and LO when it is 0. rd_stall_o is high exactly when rd_req_i and busy_o are both high.
- R10: After reset, HI = LO = 0 and busy_o = 0.
- R11: A start presented in the very cycle busy_o falls is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 2 | Operation code (see R1 to R4) |
| src_a_i | input | 32 | Multiplicand or dividend |
| src_b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| rd_req_i | input | 1 | Core wants to read HI or LO this cycle |
| rd_sel_hi_i | input | 1 | 1 selects HI, 0 selects LO |
| rd_data_o | output | 32 | Selected result register |
| rd_stall_o | output | 1 | Read must wait for completion |

## Verification
The assertions assume that reset is applied before the first operation, and that op_i and the operands carry known values in any cycle where start_i is high. They do not assume that start_i stays low while busy: the unit itself must discard such requests. The stimulus drives every input with defined values from time zero. While operations are in flight it deliberately issues stray start pulses with random operands and random read requests, so the ignore and stall paths are exercised inside the assumed envelope.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } hilo_op_e;

endpackage

// File: rtl/hilo_sign_prep.sv
// Turns raw operands into magnitudes and records which results need negating.
module hilo_sign_prep #(
    parameter int W = 32
) (
    input  hilo_pkg::hilo_op_e op_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    output logic [W-1:0]       mag_a_o,
    output logic [W-1:0]       mag_b_o,
    output logic               is_div_o,
    output logic               neg_main_o,
    output logic               neg_rem_o
);
    import hilo_pkg::*;

    logic signed_op;
    logic a_neg;
    logic b_neg;
    logic b_zero;

    always_comb begin
        signed_op  = (op_i == OP_MUL_S) || (op_i == OP_DIV_S);
        is_div_o   = (op_i == OP_DIV_S) || (op_i == OP_DIV_U);
        a_neg      = signed_op && a_i[W-1];
        b_neg      = signed_op && b_i[W-1];
        b_zero     = (b_i == '0);
        mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
        // a zero divisor keeps the all-ones quotient untouched
        neg_main_o = (a_neg ^ b_neg) && !(is_div_o && b_zero);
        neg_rem_o  = is_div_o && a_neg;
    end

endmodule

// File: rtl/hilo_iter_engine.sv
// One shift-add or one restoring-divide step per cycle on unsigned magnitudes.
module hilo_iter_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         is_div_i,
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    output logic         done_o,
    output logic [W-1:0] acc_hi_o,
    output logic [W-1:0] acc_lo_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic          div;
        logic [CW-1:0] cnt;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
        logic [W-1:0]  opnd;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [W:0] trial;
    logic [W:0] sum;

    assign trial = {eng_q.hi, eng_q.lo[W-1]} - {1'b0, eng_q.opnd};
    assign sum   = {1'b0, eng_q.hi} + (eng_q.lo[0] ? {1'b0, eng_q.opnd} : '0);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (load_i) begin
            eng_d.run  = 1'b1;
            eng_d.div  = is_div_i;
            eng_d.cnt  = '0;
            eng_d.hi   = '0;
            eng_d.lo   = mag_a_i;
            eng_d.opnd = mag_b_i;
        end else if (eng_q.run) begin
            if (eng_q.div) begin
                if (!trial[W]) begin
                    eng_d.hi = trial[W-1:0];
                    eng_d.lo = {eng_q.lo[W-2:0], 1'b1};
                end else begin
                    eng_d.hi = {eng_q.hi[W-2:0], eng_q.lo[W-1]};
                    eng_d.lo = {eng_q.lo[W-2:0], 1'b0};
                end
            end else begin
                eng_d.hi = sum[W:1];
                eng_d.lo = {sum[0], eng_q.lo[W-1:1]};
            end
            eng_d.cnt = eng_q.cnt + 1'b1;
            if (eng_q.cnt == LAST) begin
                eng_d.run  = 1'b0;
                eng_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign done_o   = eng_q.done;
    assign acc_hi_o = eng_q.hi;
    assign acc_lo_o = eng_q.lo;

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.done |=> !eng_q.done);

    // R6: the final step always produces completion on the next cycle
    p_last_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.run && eng_q.cnt == LAST && !load_i) |=> (eng_q.done && !eng_q.run));

endmodule

// File: rtl/hilo_sign_fix.sv
// Applies result signs to the raw magnitude results.
module hilo_sign_fix #(
    parameter int W = 32
) (
    input  logic         is_div_i,
    input  logic         neg_main_i,
    input  logic         neg_rem_i,
    input  logic [W-1:0] raw_hi_i,
    input  logic [W-1:0] raw_lo_i,
    output logic [W-1:0] fix_hi_o,
    output logic [W-1:0] fix_lo_o
);
    logic [2*W-1:0] prod;
    logic [2*W-1:0] prod_neg;

    always_comb begin
        prod     = {raw_hi_i, raw_lo_i};
        prod_neg = ~prod + 1'b1;
        if (is_div_i) begin
            fix_lo_o = neg_main_i ? (~raw_lo_i + 1'b1) : raw_lo_i;
            fix_hi_o = neg_rem_i  ? (~raw_hi_i + 1'b1) : raw_hi_i;
        end else begin
            {fix_hi_o, fix_lo_o} = neg_main_i ? prod_neg : prod;
        end
    end

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] src_a_i,
    input  logic [W-1:0] src_b_i,
    output logic         busy_o,
    input  logic         rd_req_i,
    input  logic         rd_sel_hi_i,
    output logic [W-1:0] rd_data_o,
    output logic         rd_stall_o
);
    import hilo_pkg::*;

    typedef struct packed {
        logic         busy;
        logic         is_div;
        logic         neg_main;
        logic         neg_rem;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } unit_t;

    unit_t st_d, st_q;

    logic         accept;
    logic [W-1:0] mag_a, mag_b;
    logic         pre_div, pre_neg_main, pre_neg_rem;
    logic         eng_done;
    logic [W-1:0] raw_hi, raw_lo;
    logic [W-1:0] fix_hi, fix_lo;

    assign accept = start_i && !st_q.busy;

    hilo_sign_prep #(.W(W)) u_prep (
        .op_i      (hilo_op_e'(op_i)),
        .a_i       (src_a_i),
        .b_i       (src_b_i),
        .mag_a_o   (mag_a),
        .mag_b_o   (mag_b),
        .is_div_o  (pre_div),
        .neg_main_o(pre_neg_main),
        .neg_rem_o (pre_neg_rem)
    );

    hilo_iter_engine #(.W(W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .is_div_i(pre_div),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .done_o  (eng_done),
        .acc_hi_o(raw_hi),
        .acc_lo_o(raw_lo)
    );

    hilo_sign_fix #(.W(W)) u_fix (
        .is_div_i  (st_q.is_div),
        .neg_main_i(st_q.neg_main),
        .neg_rem_i (st_q.neg_rem),
        .raw_hi_i  (raw_hi),
        .raw_lo_i  (raw_lo),
        .fix_hi_o  (fix_hi),
        .fix_lo_o  (fix_lo)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.is_div   = pre_div;
            st_d.neg_main = pre_neg_main;
            st_d.neg_rem  = pre_neg_rem;
        end
        if (eng_done) begin
            st_d.busy = 1'b0;
            st_d.hi   = fix_hi;
            st_d.lo   = fix_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.busy;
    assign rd_data_o  = rd_sel_hi_i ? st_q.hi : st_q.lo;
    assign rd_stall_o = rd_req_i && st_q.busy;

    // R6: an accepted start makes the unit busy on the next cycle
    p_busy_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6: engine completion frees the unit
    p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy_o);

    // R7: result registers hold while the engine is still working
    p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !eng_done) |=> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R8: a busy unit stays busy whatever start_i does, until completion
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !eng_done) |=> busy_o);

endmodule

// File: tb/hilo_muldiv_unit_test.sv
`timescale 1ns/1ps
module hilo_muldiv_unit_test;
    localparam int W   = 32;
    localparam int LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         busy;
    logic         rd_req = 1'b0;
    logic         rd_sel_hi = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_stall;

    always #2.5 clk = ~clk;

    hilo_muldiv_unit #(.W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .op_i       (op),
        .src_a_i    (a),
        .src_b_i    (b),
        .busy_o     (busy),
        .rd_req_i   (rd_req),
        .rd_sel_hi_i(rd_sel_hi),
        .rd_data_o  (rd_data),
        .rd_stall_o (rd_stall)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void ref_calc(input logic [1:0] f_op, input logic [W-1:0] fa, input logic [W-1:0] fb,
                                     output logic [W-1:0] fh, output logic [W-1:0] fl, output string ft);
        longint sa, sb, r64;
        sa = longint'($signed(fa));
        sb = longint'($signed(fb));
        case (f_op)
            2'b00: begin r64 = sa * sb; fh = r64[63:32]; fl = r64[31:0]; ft = "R1"; end
            2'b01: begin
                r64 = longint'({32'b0, fa}) * longint'({32'b0, fb});
                fh = r64[63:32]; fl = r64[31:0]; ft = "R2";
            end
            2'b10: begin
                if (fb == '0) begin fh = fa; fl = '1; ft = "R5"; end
                else begin r64 = sa / sb; fl = r64[31:0]; r64 = sa % sb; fh = r64[31:0]; ft = "R3"; end
            end
            default: begin
                if (fb == '0) begin fh = fa; fl = '1; ft = "R5"; end
                else begin fl = fa / fb; fh = fa % fb; ft = "R4"; end
            end
        endcase
    endfunction

    // behavioural reference: busy countdown and pending result
    logic         m_busy = 1'b0;
    int           m_cnt  = 0;
    logic [W-1:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
    string        m_tag = "R10", p_tag = "R10";
    logic [W-1:0] t_hi, t_lo;
    string        t_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_cnt <= 0; m_hi <= '0; m_lo <= '0; m_tag <= "R10";
        end else if (!m_busy && start) begin
            ref_calc(op, a, b, t_hi, t_lo, t_tag);
            p_hi <= t_hi; p_lo <= t_lo; p_tag <= t_tag;
            m_busy <= 1'b1; m_cnt <= LAT;
        end else if (m_busy) begin
            if (start) p_tag <= "R8";
            if (m_cnt == 1) begin
                m_busy <= 1'b0; m_hi <= p_hi; m_lo <= p_lo; m_tag <= p_tag;
            end
            m_cnt <= m_cnt - 1;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        string btag, rtag;
        #0.5;
        btag = !rst_n ? "R10" : "R6 R11";
        rtag = !rst_n ? "R10" : (m_busy ? "R7" : m_tag);
        check(btag, {31'b0, busy}, {31'b0, m_busy});
        check("R9 stall", {31'b0, rd_stall}, {31'b0, rd_req & m_busy});
        rd_sel_hi = 1'b1;
        #0.5;
        check({rtag, " HI R9"}, rd_data, m_hi);
        rd_sel_hi = 1'b0;
        #0.5;
        check({rtag, " LO R9"}, rd_data, m_lo);
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            report();
            $finish;
        end
    end

    // called at a falling edge with the unit idle; returns at the falling edge where busy drops
    task automatic issue(input logic [1:0] t_op, input logic [W-1:0] ta, input logic [W-1:0] tb, input bit poke);
        start = 1'b1; op = t_op; a = ta; b = tb;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) begin
            rd_req = 1'($urandom % 2);
            if (poke) begin  // R8 stray starts while busy
                start = 1'($urandom % 2);
                op = 2'($urandom); a = $urandom; b = $urandom;
            end
            @(negedge clk);
        end
        start = 1'b0;
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 signed multiply
        issue(2'b00, -32'sd3, 32'sd7, 0);
        issue(2'b00, 32'h8000_0000, 32'h8000_0000, 0);
        issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        // R2 unsigned multiply
        issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 1);
        // R3 signed divide, including the overflow pair
        issue(2'b10, -32'sd7, 32'sd2, 0);
        issue(2'b10, 32'sd7, -32'sd2, 0);
        issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        // R4 unsigned divide
        issue(2'b11, 32'd100, 32'd7, 0);
        issue(2'b11, 32'hFFFF_FFFF, 32'd1, 1);
        // R5 divide by zero, both signedness
        issue(2'b10, -32'sd5, 32'd0, 0);
        issue(2'b11, 32'd123, 32'd0, 0);
        // R11 back to back was exercised above; now with idle gaps and random data
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] rb;
            rb = $urandom;
            if (i % 5 == 0) rb = '0;
            else if (i % 3 == 0) rb = rb >> ($urandom % 32);
            if (i % 4 == 0) @(negedge clk);
            issue(2'($urandom), $urandom, rb, (i % 2) == 1);
        end
        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule